// File: doc/BRIEF.md
# Multi-Wavefront Instruction Fetch Controller

This block sits at the front of a compute unit and keeps a program counter for each resident wavefront. A dispatcher hands over a wavefront by giving its starting PC, the base and extent of its vector register, scalar register and local-memory windows, and an identifier. The block stores this context in a free slot, and later decode stages can read it back through a lookup port.

Each cycle the block chooses one wavefront that is able to fetch. It sends that wavefront's address and slot number to an instruction memory that always hits, and passes the returned word, tagged with its slot, on to the instruction queues. The PC advances when the word comes back. A word can mark the first half of a 64-bit instruction; in that case the second word is fetched next, and the PC then moves on by eight. Branch redirects overwrite a PC and cancel any fetch still in flight for it. An end-of-program notice frees the slot and returns the wavefront's identifier to the dispatcher.

Top module: `wf_fetch_ctrl`

## Requirements
- R1: A dispatch handshake (`disp_valid` and `disp_ready` both high) writes the PC, identifier and the three base/size pairs into the lowest-numbered free slot, which `disp_slot` reports. From the next cycle `ctx_*` returns those values for that slot, with `ctx_valid` high.
- R2: A slot is free when it holds no wavefront and has no fetch outstanding. `disp_ready` is low when no slot is free, and a dispatch offered then changes no slot.
- R3: At most one fetch request is issued per cycle. It carries the index of the requesting slot on `imem_req_slot`.
- R4: A slot may fetch when it is occupied, its `ifq_full` bit is low, it has no fetch outstanding, and it is not named by `br_valid` or `end_valid` in that cycle. Among such slots the grant goes to the first one after the previously granted slot, in ascending order with wrap-around. After reset, slot 0 is first.
- R5: A response for a live slot is presented on `ifq_valid`, `ifq_slot` and `ifq_instr` in the cycle after it arrives.
- R6: A slot fetches at its PC. A forwarded word whose bits [31:30] equal 2'b11 starts a 64-bit instruction. The slot's next fetch is then at PC+4 with `ifq_second` set on its return, and afterwards the PC moves on by 8. Any other word moves the PC on by 4.
- R7: A redirect on an occupied slot sets its PC to `br_target` and clears any pending second half. A response that was outstanding at the time of the redirect, or that arrives in the same cycle, is not forwarded.
- R8: An end notice on an occupied slot frees the slot. One cycle later it raises `done_valid` for one cycle, with the identifier given at dispatch. The end notice takes precedence over a redirect to the same slot in the same cycle.
- R9: After reset no slot is occupied: `disp_ready` is high, `disp_slot` is 0, and no fetch, forward or completion is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatcher offers a wavefront |
| disp_ready | output | 1 | A slot is free |
| disp_slot | output | 6 | Slot that an offered wavefront takes |
| disp_pc | input | 32 | Starting PC |
| disp_wf_id | input | 6 | Wavefront identifier |
| disp_vbase | input | 10 | Vector register window base |
| disp_vsize | input | 10 | Vector register window size |
| disp_sbase | input | 9 | Scalar register window base |
| disp_ssize | input | 9 | Scalar register window size |
| disp_lbase | input | 16 | Local memory window base |
| disp_lsize | input | 16 | Local memory window size |
| imem_req_valid | output | 1 | Fetch request |
| imem_req_slot | output | 6 | Requesting slot |
| imem_req_addr | output | 32 | Fetch byte address |
| imem_rsp_valid | input | 1 | Fetched word returns |
| imem_rsp_slot | input | 6 | Slot of the returning word |
| imem_rsp_data | input | 32 | Returned word |
| ifq_full | input | 40 | Per-slot instruction queue full |
| ifq_valid | output | 1 | Word forwarded to a queue |
| ifq_slot | output | 6 | Destination queue |
| ifq_instr | output | 32 | Forwarded word |
| ifq_second | output | 1 | Word is second half of a 64-bit instruction |
| br_valid | input | 1 | Branch redirect |
| br_slot | input | 6 | Redirected slot |
| br_target | input | 32 | New PC |
| end_valid | input | 1 | End of program |
| end_slot | input | 6 | Finished slot |
| done_valid | output | 1 | Completion to dispatcher |
| done_wf_id | output | 6 | Identifier of finished wavefront |
| ctx_slot | input | 6 | Context lookup slot |
| ctx_valid | output | 1 | Looked-up slot is occupied |
| ctx_pc | output | 32 | Current PC of looked-up slot |
| ctx_wf_id | output | 6 | Identifier of looked-up slot |
| ctx_vbase | output | 10 | Vector register base |
| ctx_vsize | output | 10 | Vector register size |
| ctx_sbase | output | 9 | Scalar register base |
| ctx_ssize | output | 9 | Scalar register size |
| ctx_lbase | output | 16 | Local memory base |
| ctx_lsize | output | 16 | Local memory size |

## Verification
The bench fills all forty slots and keeps offering dispatches. A design that ignored the full condition would overwrite a live context, and a design that freed a slot with a fetch still outstanding would hand a stale word to the new wavefront. It forces a redirect and an end notice onto the same slot, and it times redirects to hit both in-flight fetches and same-cycle responses. A wrong priority shows up as a missing completion or as a forwarded word from the old path. Random words marked as 64-bit starts exercise the second-half fetch: an early PC step would skip or repeat a word. Random queue-full masks exercise the round-robin pointer: a wrong pointer grants the wrong slot or starves one.

// File: rtl/wf_fetch_pkg.sv
package wf_fetch_pkg;
    parameter int PC_W    = 32;
    parameter int INSTR_W = 32;
    parameter int WFID_W  = 6;
    parameter int VREG_W  = 10;
    parameter int SREG_W  = 9;
    parameter int LDS_W   = 16;
    localparam logic [1:0] LONG_MARK = 2'b11;

    typedef struct packed {
        logic [WFID_W-1:0] wf_id;
        logic [VREG_W-1:0] vbase;
        logic [VREG_W-1:0] vsize;
        logic [SREG_W-1:0] sbase;
        logic [SREG_W-1:0] ssize;
        logic [LDS_W-1:0]  lbase;
        logic [LDS_W-1:0]  lsize;
    } wf_ctx_t;

    typedef struct packed {
        logic            valid;
        logic            inflight;
        logic            drop;
        logic            half;
        logic [PC_W-1:0] pc;
        wf_ctx_t         ctx;
    } wf_slot_t;
endpackage

// File: rtl/wf_rr_pick.sv
module wf_rr_pick #(
    parameter int N = 40,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [SW-1:0] last,
    output logic          gnt_v,
    output logic [SW-1:0] gnt_idx
);
    always_comb begin
        gnt_v   = 1'b0;
        gnt_idx = '0;
        // Walk from farthest to nearest so the slot right after 'last' wins.
        for (int off = N; off >= 1; off--) begin
            automatic int idx = int'(last) + off;
            if (idx >= N) idx = idx - N;
            if (req[idx]) begin
                gnt_v   = 1'b1;
                gnt_idx = SW'(idx);
            end
        end
    end
endmodule

// File: rtl/wf_first_free.sv
module wf_first_free #(
    parameter int N = 40,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  free,
    output logic          any,
    output logic [SW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                any = 1'b1;
                idx = SW'(i);
            end
        end
    end
endmodule

// File: rtl/wf_fetch_ctrl.sv
module wf_fetch_ctrl
    import wf_fetch_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 disp_valid,
    output logic                 disp_ready,
    output logic [SW-1:0]        disp_slot,
    input  logic [PC_W-1:0]      disp_pc,
    input  logic [WFID_W-1:0]    disp_wf_id,
    input  logic [VREG_W-1:0]    disp_vbase,
    input  logic [VREG_W-1:0]    disp_vsize,
    input  logic [SREG_W-1:0]    disp_sbase,
    input  logic [SREG_W-1:0]    disp_ssize,
    input  logic [LDS_W-1:0]     disp_lbase,
    input  logic [LDS_W-1:0]     disp_lsize,
    output logic                 imem_req_valid,
    output logic [SW-1:0]        imem_req_slot,
    output logic [PC_W-1:0]      imem_req_addr,
    input  logic                 imem_rsp_valid,
    input  logic [SW-1:0]        imem_rsp_slot,
    input  logic [INSTR_W-1:0]   imem_rsp_data,
    input  logic [NUM_SLOTS-1:0] ifq_full,
    output logic                 ifq_valid,
    output logic [SW-1:0]        ifq_slot,
    output logic [INSTR_W-1:0]   ifq_instr,
    output logic                 ifq_second,
    input  logic                 br_valid,
    input  logic [SW-1:0]        br_slot,
    input  logic [PC_W-1:0]      br_target,
    input  logic                 end_valid,
    input  logic [SW-1:0]        end_slot,
    output logic                 done_valid,
    output logic [WFID_W-1:0]    done_wf_id,
    input  logic [SW-1:0]        ctx_slot,
    output logic                 ctx_valid,
    output logic [PC_W-1:0]      ctx_pc,
    output logic [WFID_W-1:0]    ctx_wf_id,
    output logic [VREG_W-1:0]    ctx_vbase,
    output logic [VREG_W-1:0]    ctx_vsize,
    output logic [SREG_W-1:0]    ctx_sbase,
    output logic [SREG_W-1:0]    ctx_ssize,
    output logic [LDS_W-1:0]     ctx_lbase,
    output logic [LDS_W-1:0]     ctx_lsize
);
    typedef struct packed {
        wf_slot_t [NUM_SLOTS-1:0] slot;
        logic [SW-1:0]            rr_last;
        logic                     done_v;
        logic [WFID_W-1:0]        done_id;
        logic                     ifq_v;
        logic [SW-1:0]            ifq_slot;
        logic [INSTR_W-1:0]       ifq_instr;
        logic                     ifq_second;
    } state_t;

    state_t state_q, state_d;

    logic [NUM_SLOTS-1:0] free_vec, elig_vec;
    logic                 pick_v, free_any;
    logic [SW-1:0]        pick_idx, free_idx;
    logic                 end_ok, br_ok, rsp_live, rsp_fwd, disp_fire;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign free_vec[g] = !state_q.slot[g].valid && !state_q.slot[g].inflight;
        assign elig_vec[g] = state_q.slot[g].valid && !state_q.slot[g].inflight && !ifq_full[g]
                           && !(br_valid && br_slot == SW'(g))
                           && !(end_valid && end_slot == SW'(g));
    end

    wf_rr_pick #(.N(NUM_SLOTS)) i_pick (
        .req(elig_vec), .last(state_q.rr_last), .gnt_v(pick_v), .gnt_idx(pick_idx)
    );

    wf_first_free #(.N(NUM_SLOTS)) i_free (
        .free(free_vec), .any(free_any), .idx(free_idx)
    );

    assign end_ok    = end_valid && state_q.slot[end_slot].valid;
    assign br_ok     = br_valid && state_q.slot[br_slot].valid && !(end_ok && end_slot == br_slot);
    assign rsp_live  = imem_rsp_valid && state_q.slot[imem_rsp_slot].inflight;
    assign rsp_fwd   = rsp_live && !state_q.slot[imem_rsp_slot].drop && state_q.slot[imem_rsp_slot].valid
                     && !(br_valid && br_slot == imem_rsp_slot)
                     && !(end_valid && end_slot == imem_rsp_slot);
    assign disp_fire = disp_valid && free_any;

    always_comb begin
        state_d        = state_q;
        state_d.done_v = 1'b0;
        state_d.ifq_v  = 1'b0;
        if (rsp_live) begin
            state_d.slot[imem_rsp_slot].inflight = 1'b0;
            state_d.slot[imem_rsp_slot].drop     = 1'b0;
        end
        if (rsp_fwd) begin
            state_d.ifq_v      = 1'b1;
            state_d.ifq_slot   = imem_rsp_slot;
            state_d.ifq_instr  = imem_rsp_data;
            state_d.ifq_second = state_q.slot[imem_rsp_slot].half;
            if (state_q.slot[imem_rsp_slot].half) begin
                state_d.slot[imem_rsp_slot].pc   = state_q.slot[imem_rsp_slot].pc + PC_W'(8);
                state_d.slot[imem_rsp_slot].half = 1'b0;
            end else if (imem_rsp_data[INSTR_W-1 -: 2] == LONG_MARK) begin
                state_d.slot[imem_rsp_slot].half = 1'b1;
            end else begin
                state_d.slot[imem_rsp_slot].pc   = state_q.slot[imem_rsp_slot].pc + PC_W'(4);
            end
        end
        if (pick_v) begin
            state_d.slot[pick_idx].inflight = 1'b1;
            state_d.rr_last                 = pick_idx;
        end
        if (end_ok) begin
            state_d.slot[end_slot].valid = 1'b0;
            state_d.done_v               = 1'b1;
            state_d.done_id              = state_q.slot[end_slot].ctx.wf_id;
        end
        if (br_ok) begin
            state_d.slot[br_slot].pc   = br_target;
            state_d.slot[br_slot].half = 1'b0;
            state_d.slot[br_slot].drop = state_d.slot[br_slot].inflight;
        end
        if (disp_fire) begin
            state_d.slot[free_idx].valid     = 1'b1;
            state_d.slot[free_idx].inflight  = 1'b0;
            state_d.slot[free_idx].drop      = 1'b0;
            state_d.slot[free_idx].half      = 1'b0;
            state_d.slot[free_idx].pc        = disp_pc;
            state_d.slot[free_idx].ctx.wf_id = disp_wf_id;
            state_d.slot[free_idx].ctx.vbase = disp_vbase;
            state_d.slot[free_idx].ctx.vsize = disp_vsize;
            state_d.slot[free_idx].ctx.sbase = disp_sbase;
            state_d.slot[free_idx].ctx.ssize = disp_ssize;
            state_d.slot[free_idx].ctx.lbase = disp_lbase;
            state_d.slot[free_idx].ctx.lsize = disp_lsize;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.rr_last <= SW'(NUM_SLOTS - 1);
        end else begin
            state_q <= state_d;
        end
    end

    assign disp_ready     = free_any;
    assign disp_slot      = free_idx;
    assign imem_req_valid = pick_v;
    assign imem_req_slot  = pick_idx;
    assign imem_req_addr  = state_q.slot[pick_idx].pc + (state_q.slot[pick_idx].half ? PC_W'(4) : PC_W'(0));
    assign ifq_valid      = state_q.ifq_v;
    assign ifq_slot       = state_q.ifq_slot;
    assign ifq_instr      = state_q.ifq_instr;
    assign ifq_second     = state_q.ifq_second;
    assign done_valid     = state_q.done_v;
    assign done_wf_id     = state_q.done_id;
    assign ctx_valid      = state_q.slot[ctx_slot].valid;
    assign ctx_pc         = state_q.slot[ctx_slot].pc;
    assign ctx_wf_id      = state_q.slot[ctx_slot].ctx.wf_id;
    assign ctx_vbase      = state_q.slot[ctx_slot].ctx.vbase;
    assign ctx_vsize      = state_q.slot[ctx_slot].ctx.vsize;
    assign ctx_sbase      = state_q.slot[ctx_slot].ctx.sbase;
    assign ctx_ssize      = state_q.slot[ctx_slot].ctx.ssize;
    assign ctx_lbase      = state_q.slot[ctx_slot].ctx.lbase;
    assign ctx_lsize      = state_q.slot[ctx_slot].ctx.lsize;

    // R1
    disp_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_ready |=> state_q.slot[$past(disp_slot)].valid
                                     && state_q.slot[$past(disp_slot)].pc == $past(disp_pc));
    // R4
    no_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req_valid |=> !(imem_req_valid && imem_req_slot == $past(imem_req_slot)));
    // R5
    ifq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifq_valid |-> $past(imem_rsp_valid) && $past(imem_rsp_slot) == ifq_slot
                      && $past(imem_rsp_data) == ifq_instr);
    // R7
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && state_q.slot[br_slot].valid && !(end_valid && end_slot == br_slot)
        |=> state_q.slot[$past(br_slot)].pc == $past(br_target));
    // R8
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_valid && state_q.slot[end_slot].valid
        |=> done_valid && done_wf_id == $past(state_q.slot[end_slot].ctx.wf_id));
endmodule

// File: tb/test_wf_fetch_ctrl.sv
module test_wf_fetch_ctrl;
    import wf_fetch_pkg::*;
    localparam int N = 40;
    localparam int SW = $clog2(N);
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 0, disp_ready; logic [SW-1:0] disp_slot;
    logic [PC_W-1:0] disp_pc = 0; logic [WFID_W-1:0] disp_wf_id = 0;
    logic [VREG_W-1:0] disp_vbase = 0, disp_vsize = 0;
    logic [SREG_W-1:0] disp_sbase = 0, disp_ssize = 0;
    logic [LDS_W-1:0] disp_lbase = 0, disp_lsize = 0;
    logic imem_req_valid; logic [SW-1:0] imem_req_slot; logic [PC_W-1:0] imem_req_addr;
    logic imem_rsp_valid = 0; logic [SW-1:0] imem_rsp_slot = 0; logic [INSTR_W-1:0] imem_rsp_data = 0;
    logic [N-1:0] ifq_full = '0;
    logic ifq_valid, ifq_second; logic [SW-1:0] ifq_slot; logic [INSTR_W-1:0] ifq_instr;
    logic br_valid = 0; logic [SW-1:0] br_slot = 0; logic [PC_W-1:0] br_target = 0;
    logic end_valid = 0; logic [SW-1:0] end_slot = 0;
    logic done_valid; logic [WFID_W-1:0] done_wf_id;
    logic [SW-1:0] ctx_slot = 0; logic ctx_valid; logic [PC_W-1:0] ctx_pc; logic [WFID_W-1:0] ctx_wf_id;
    logic [VREG_W-1:0] ctx_vbase, ctx_vsize; logic [SREG_W-1:0] ctx_sbase, ctx_ssize;
    logic [LDS_W-1:0] ctx_lbase, ctx_lsize;

    always #(CLK_PERIOD/2) clk = ~clk;

    wf_fetch_ctrl #(.NUM_SLOTS(N)) i_wf_fetch_ctrl (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    bit m_valid[N], m_infl[N], m_drop[N], m_half[N];
    logic [31:0] m_pc[N]; wf_ctx_t m_ctx[N];
    int m_rr;
    bit m_done_v; logic [WFID_W-1:0] m_done_id;
    bit m_ifq_v, m_ifq_sec; int m_ifq_slot; logic [31:0] m_ifq_instr;
    bit pv[LAT]; int ps[LAT]; logic [31:0] pa[LAT];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w = (a * 32'h9E3779B1) ^ 32'h5A5A1234;
        w[31:30] = (a[6:2] % 5 == 0) ? 2'b11 : {1'b0, w[30]};
        return w;
    endfunction

    function automatic int first_free();
        for (int i = 0; i < N; i++) if (!m_valid[i] && !m_infl[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_infl[i] = 0; m_drop[i] = 0; m_half[i] = 0; m_pc[i] = 0; m_ctx[i] = '0;
        end
        for (int i = 0; i < LAT; i++) begin pv[i] = 0; ps[i] = 0; pa[i] = 0; end
        m_rr = N - 1; m_done_v = 0; m_ifq_v = 0;
    endtask

    task automatic step(input int p_disp, input int p_br, input int p_end, input int p_full, input int force_slot);
        bit elig[N]; int pick, ff, rs; bit fwd, endok, brok, dfire;
        logic [31:0] rdata;
        @(negedge clk);
        imem_rsp_valid = pv[LAT-1]; imem_rsp_slot = SW'(ps[LAT-1]); rdata = mem_word(pa[LAT-1]);
        imem_rsp_data = rdata;
        for (int i = LAT - 1; i > 0; i--) begin pv[i] = pv[i-1]; ps[i] = ps[i-1]; pa[i] = pa[i-1]; end
        pv[0] = 0;
        disp_valid = ($urandom % 100) < p_disp;
        disp_pc = $urandom & 32'hFFFF_FFFC; disp_wf_id = WFID_W'($urandom);
        disp_vbase = VREG_W'($urandom); disp_vsize = VREG_W'($urandom);
        disp_sbase = SREG_W'($urandom); disp_ssize = SREG_W'($urandom);
        disp_lbase = LDS_W'($urandom); disp_lsize = LDS_W'($urandom);
        br_valid = ($urandom % 100) < p_br; br_slot = SW'($urandom % N); br_target = $urandom & 32'hFFFF_FFFC;
        end_valid = ($urandom % 100) < p_end; end_slot = SW'($urandom % N);
        if (force_slot >= 0) begin
            br_valid = 1; end_valid = 1; br_slot = SW'(force_slot); end_slot = SW'(force_slot);
        end
        for (int i = 0; i < N; i++) ifq_full[i] = ($urandom % 100) < p_full;
        ctx_slot = SW'($urandom % N);
        #1;
        // registered outputs
        check(ifq_valid == m_ifq_v, "R5 ifq_valid", 64'(ifq_valid), 64'(m_ifq_v));
        if (m_ifq_v) begin
            check(ifq_slot == SW'(m_ifq_slot), "R5 ifq_slot", 64'(ifq_slot), 64'(m_ifq_slot));
            check(ifq_instr == m_ifq_instr, "R5 ifq_instr", 64'(ifq_instr), 64'(m_ifq_instr));
            check(ifq_second == m_ifq_sec, "R6 ifq_second", 64'(ifq_second), 64'(m_ifq_sec));
        end
        check(done_valid == m_done_v, "R8 done_valid", 64'(done_valid), 64'(m_done_v));
        if (m_done_v) check(done_wf_id == m_done_id, "R8 done_wf_id", 64'(done_wf_id), 64'(m_done_id));
        check(ctx_valid == m_valid[ctx_slot], "R1 ctx_valid", 64'(ctx_valid), 64'(m_valid[ctx_slot]));
        if (m_valid[ctx_slot]) begin
            check(ctx_pc == m_pc[ctx_slot], "R6 R7 ctx_pc", 64'(ctx_pc), 64'(m_pc[ctx_slot]));
            check({ctx_wf_id, ctx_vbase, ctx_vsize, ctx_sbase, ctx_ssize, ctx_lbase, ctx_lsize} == m_ctx[ctx_slot],
                  "R1 ctx fields", 64'({ctx_wf_id, ctx_vbase, ctx_lsize}), 64'({m_ctx[ctx_slot].wf_id, m_ctx[ctx_slot].vbase, m_ctx[ctx_slot].lsize}));
        end
        // combinational outputs
        ff = first_free();
        check(disp_ready == (ff >= 0), "R2 disp_ready", 64'(disp_ready), 64'(ff >= 0));
        if (ff >= 0) check(disp_slot == SW'(ff), "R1 disp_slot", 64'(disp_slot), 64'(ff));
        for (int i = 0; i < N; i++)
            elig[i] = m_valid[i] && !m_infl[i] && !ifq_full[i] && !(br_valid && br_slot == SW'(i))
                      && !(end_valid && end_slot == SW'(i));
        pick = -1;
        for (int off = 1; off <= N; off++) if (pick < 0 && elig[(m_rr + off) % N]) pick = (m_rr + off) % N;
        check(imem_req_valid == (pick >= 0), "R4 req_valid", 64'(imem_req_valid), 64'(pick >= 0));
        if (pick >= 0) begin
            check(imem_req_slot == SW'(pick), "R3 R4 req_slot", 64'(imem_req_slot), 64'(pick));
            check(imem_req_addr == m_pc[pick] + (m_half[pick] ? 32'd4 : 32'd0), "R6 R7 req_addr",
                  64'(imem_req_addr), 64'(m_pc[pick] + (m_half[pick] ? 32'd4 : 32'd0)));
        end
        if (imem_req_valid) begin pv[0] = 1; ps[0] = int'(imem_req_slot); pa[0] = imem_req_addr; end
        // model update at the coming edge
        rs = int'(imem_rsp_slot);
        endok = end_valid && m_valid[end_slot];
        brok = br_valid && m_valid[br_slot] && !(endok && end_slot == br_slot);
        dfire = disp_valid && ff >= 0;
        m_ifq_v = 0; m_done_v = 0;
        if (imem_rsp_valid && m_infl[rs]) begin
            fwd = !m_drop[rs] && m_valid[rs] && !(br_valid && br_slot == SW'(rs)) && !(end_valid && end_slot == SW'(rs));
            m_infl[rs] = 0; m_drop[rs] = 0;
            if (fwd) begin
                m_ifq_v = 1; m_ifq_slot = rs; m_ifq_instr = rdata; m_ifq_sec = m_half[rs];
                if (m_half[rs]) begin m_pc[rs] += 8; m_half[rs] = 0; end
                else if (rdata[31:30] == 2'b11) m_half[rs] = 1;
                else m_pc[rs] += 4;
            end
        end
        if (pick >= 0) begin m_infl[pick] = 1; m_rr = pick; end
        if (endok) begin m_valid[end_slot] = 0; m_done_v = 1; m_done_id = m_ctx[end_slot].wf_id; end
        if (brok) begin m_pc[br_slot] = br_target; m_half[br_slot] = 0; m_drop[br_slot] = m_infl[br_slot]; end
        if (dfire) begin
            m_valid[ff] = 1; m_infl[ff] = 0; m_drop[ff] = 0; m_half[ff] = 0; m_pc[ff] = disp_pc;
            m_ctx[ff] = '{disp_wf_id, disp_vbase, disp_vsize, disp_sbase, disp_ssize, disp_lbase, disp_lsize};
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check(disp_ready == 1'b1, "R9 disp_ready after reset", 64'(disp_ready), 64'd1);
        check(disp_slot == '0, "R9 disp_slot after reset", 64'(disp_slot), 64'd0);
        check(!imem_req_valid && !ifq_valid && !done_valid, "R9 quiet outputs",
              64'({imem_req_valid, ifq_valid, done_valid}), 64'd0);
        // fill every slot, keep offering: R2 refusal
        for (int c = 0; c < 60; c++) step(100, 0, 0, 30, -1);
        check(disp_ready == 1'b0, "R2 all slots busy", 64'(disp_ready), 64'd0);
        // redirects into running fetches
        for (int c = 0; c < 300; c++) step(100, 40, 0, 20, -1);
        // end and redirect on one slot together: end wins (R8)
        step(0, 0, 0, 0, 5);
        step(0, 0, 0, 0, 12);
        for (int c = 0; c < 4; c++) step(0, 0, 0, 0, -1);
        // long random mix
        for (int c = 0; c < 6000; c++) step(40, 15, 10, 25, -1);
        // drain and finish slots
        for (int c = 0; c < 200; c++) step(0, 0, 60, 0, -1);
        check(disp_ready == 1'b1, "R2 slots freed after ends", 64'(disp_ready), 64'd1);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule